// File: doc/BRIEF.md
# Byte-Packing Host Data Buffer

This block sits between a 32-bit host bus and a byte-wide card data path. It holds two 32-byte circular byte queues, one per direction. On the bus side one access moves one, two or four bytes at a time. On a write the bytes are unpacked into the transmit queue, and on a read they are packed out of the receive queue, always starting at the most significant byte lane of the access. On the card side, bytes move one per clock over a valid/ready handshake.

A control block starts a transfer with a one-cycle load strobe. The strobe carries the byte count and the direction. The block counts the bytes down and sets service request flags that a CPU or DMA engine can act on. It also sets completion flags: data-done for any transfer, and program-done as well for a card write.

A state machine sequences the card side. In `IDLE`, a load with a nonzero count moves to `TX_HOLD` (direction 1, card write) or `RX_FILL` (direction 0, card read). `TX_HOLD` moves to `TX_SEND` once the transmit queue is full, or once a flush has been requested and the queue is not empty. `TX_SEND` returns to `TX_HOLD` when a burst empties the queue with bytes still owed. It returns to `IDLE` on the last byte of the transfer. `RX_FILL` returns to `IDLE` on the last byte.

Top module: `hbuf_top`

## Requirements
- R1: Each queue holds at most DEPTH (32) bytes, and its read and write indices wrap modulo DEPTH. A queue never accepts a byte when full and never offers one when empty.
- R2: `bus_size` selects how many bytes an access moves: 0 moves one byte, 1 moves two bytes, and 2 or 3 move four bytes.
- R3: A bus write pushes the access's bytes into the transmit queue in order. The first byte pushed comes from lane (n-1), bits [8n-1:8n-8], and the last from lane 0. Bytes that do not fit once the queue is full are dropped.
- R4: A bus read pops up to n bytes, stopping early if the queue runs empty. The first byte popped appears in lane (n-1). Every lane that is not filled reads as zero, so a read of an empty queue returns 0.
- R5: In a card read, the block accepts a card byte in `RX_FILL` only while the receive queue is not full. Each accepted byte decrements the remaining count.
- R6: `rx_req` sets when an accepted card byte fills the receive queue, or when it is the last byte of the transfer. A bus read clears `rx_req`; if a set and a clear occur in the same cycle, the set wins.
- R7: In a card write, no byte is offered while in `TX_HOLD`. In `TX_SEND`, the block offers one byte per handshake until the queue empties or the count reaches zero. Bytes reach the card in the order they were pushed.
- R8: `tx_req` sets when a card-write transfer is loaded, and again when a send burst empties the queue with bytes still owed. A bus write clears `tx_req`.
- R9: A `tx_flush` strobe lets a partly filled transmit queue drain to the card without waiting for it to fill.
- R10: When the count reaches zero, `data_done` sets. In a card write, `prog_done` sets as well. A load, which is accepted only in `IDLE`, clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Bus read of the receive queue, for one cycle |
| bus_wr | input | 1 | Bus write to the transmit queue, for one cycle |
| bus_size | input | 2 | Access width code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Packed read data, valid while `bus_rd` is high |
| tx_flush | input | 1 | Partial-buffer flush strobe |
| xfer_load | input | 1 | Transfer start strobe |
| xfer_dir | input | 1 | 1 = card write, 0 = card read |
| xfer_bytes | input | CNT_W | Byte count of the transfer |
| card_tx_valid | output | 1 | Byte offered to the card |
| card_tx_ready | input | 1 | Card takes the offered byte |
| card_tx_data | output | 8 | Byte to the card |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Block takes the card byte |
| card_rx_data | input | 8 | Byte from the card |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| data_done | output | 1 | Transfer count exhausted |
| prog_done | output | 1 | Card write count exhausted |

## Verification
The bench uses the default DEPTH of 32 and CNT_W of 16. At these values, a 35-byte card read wraps the receive indices past the end of the storage. Filling the transmit queue by bus writes takes only eight word writes, so the full-queue stop, a write that is only partly accepted, and a flush of a partly filled queue can all be reached in a few hundred cycles. The 16-bit count lets a single transfer be longer than one queue's worth of bytes.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
    localparam int BUS_LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TX_HOLD = 2'd1,
        ST_TX_SEND = 2'd2,
        ST_RX_FILL = 2'd3
    } xfer_state_t;

    // Bytes moved by one bus access, from the size code.
    function automatic logic [2:0] size_to_bytes(input logic [1:0] sz);
        unique case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/hbuf_ring.sv
// Circular byte queue with a multi-byte port on one side. DEPTH must be a power of two.
module hbuf_ring #(
    parameter int DEPTH  = 32,
    parameter int PUSH_W = 4,
    parameter int POP_W  = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1,
    localparam int PN_W  = $clog2(PUSH_W + 1),
    localparam int QN_W  = $clog2(POP_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PN_W-1:0]     push_n,
    input  logic [8*PUSH_W-1:0] push_vec,
    input  logic [QN_W-1:0]     pop_n,
    output logic [LVL_W-1:0]    level,
    output logic [8*POP_W-1:0]  peek_vec
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            level  <= level + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PUSH_W; i++) begin
            if (PN_W'(i) < push_n)
                mem[wr_ptr + PTR_W'(i)] <= push_vec[8*i +: 8];
        end
    end

    always_comb begin
        for (int i = 0; i < POP_W; i++)
            peek_vec[8*i +: 8] = mem[rd_ptr + PTR_W'(i)];
    end
endmodule

// File: rtl/hbuf_xfer.sv
// Card-side sequencer: state, remaining count, completion flags.
module hbuf_xfer
    import hbuf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_load,
    input  logic             xfer_dir,
    input  logic [CNT_W-1:0] xfer_bytes,
    input  logic             tx_flush,
    input  logic             tx_empty,
    input  logic             tx_full,
    input  logic             tx_last,
    input  logic             rx_full,
    input  logic             card_tx_ready,
    input  logic             card_rx_valid,
    output logic             card_tx_valid,
    output logic             card_rx_ready,
    output logic             tx_pop,
    output logic             rx_push,
    output logic             ev_tx_start,
    output logic             ev_tx_drained,
    output logic             ev_last,
    output logic             data_done,
    output logic             prog_done
);
    xfer_state_t      st, st_nx;
    logic [CNT_W-1:0] remain;
    logic             flush_pend;
    logic             take_load;

    // Outputs and events
    always_comb begin
        take_load     = (st == ST_IDLE) && xfer_load;
        card_tx_valid = (st == ST_TX_SEND) && !tx_empty;
        card_rx_ready = (st == ST_RX_FILL) && !rx_full;
        tx_pop        = card_tx_valid && card_tx_ready;
        rx_push       = card_rx_ready && card_rx_valid;
        ev_last       = (tx_pop || rx_push) && (remain == CNT_W'(1));
        ev_tx_start   = take_load && xfer_dir && (xfer_bytes != '0);
        ev_tx_drained = tx_pop && !ev_last && tx_last;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (xfer_load && xfer_bytes != '0)
                            st_nx = xfer_dir ? ST_TX_HOLD : ST_RX_FILL;
            ST_TX_HOLD: if ((tx_full || flush_pend) && !tx_empty)
                            st_nx = ST_TX_SEND;
            ST_TX_SEND: if (ev_last)            st_nx = ST_IDLE;
                        else if (ev_tx_drained) st_nx = ST_TX_HOLD;
            ST_RX_FILL: if (ev_last)            st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain     <= '0;
            data_done  <= 1'b0;
            prog_done  <= 1'b0;
            flush_pend <= 1'b0;
        end else begin
            if (take_load)
                remain <= xfer_bytes;
            else if (tx_pop || rx_push)
                remain <= remain - CNT_W'(1);

            if (take_load) begin
                data_done <= (xfer_bytes == '0);
                prog_done <= (xfer_bytes == '0) && xfer_dir;
            end else if (ev_last) begin
                data_done <= 1'b1;
                prog_done <= prog_done | (st == ST_TX_SEND);
            end

            if (take_load)
                flush_pend <= 1'b0;
            else if (tx_flush)
                flush_pend <= 1'b1;
            else if (st == ST_TX_SEND && st_nx != ST_TX_SEND)
                flush_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/hbuf_top.sv
module hbuf_top
    import hbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_size,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             tx_flush,
    input  logic             xfer_load,
    input  logic             xfer_dir,
    input  logic [CNT_W-1:0] xfer_bytes,
    output logic             card_tx_valid,
    input  logic             card_tx_ready,
    output logic [7:0]       card_tx_data,
    input  logic             card_rx_valid,
    output logic             card_rx_ready,
    input  logic [7:0]       card_rx_data,
    output logic             rx_req,
    output logic             tx_req,
    output logic             data_done,
    output logic             prog_done
);
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic [2:0]             acc_n;
    logic [LVL_W-1:0]       tx_level, rx_level, tx_room;
    logic [2:0]             tx_push_n, rx_pop_n;
    logic [8*BUS_LANES-1:0] tx_push_vec, rx_peek;
    logic                   tx_pop, rx_push;
    logic                   ev_tx_start, ev_tx_drained, ev_last, rx_fill_evt;

    assign acc_n   = size_to_bytes(bus_size);
    assign tx_room = LVL_W'(DEPTH) - tx_level;

    // Unpack a bus write: first byte from the top lane of the access.
    always_comb begin
        int lane;
        tx_push_vec = '0;
        tx_push_n   = '0;
        for (int i = 0; i < BUS_LANES; i++) begin
            lane = int'(acc_n) - 1 - i;
            if (lane >= 0)
                tx_push_vec[8*i +: 8] = bus_wdata[8*lane +: 8];
        end
        if (bus_wr)
            tx_push_n = (LVL_W'(acc_n) <= tx_room) ? acc_n : tx_room[2:0];
    end

    // Pack a bus read: first byte popped into the top lane of the access.
    always_comb begin
        int lane;
        rx_pop_n  = '0;
        bus_rdata = '0;
        if (bus_rd)
            rx_pop_n = (LVL_W'(acc_n) <= rx_level) ? acc_n : rx_level[2:0];
        for (int i = 0; i < BUS_LANES; i++) begin
            lane = int'(acc_n) - 1 - i;
            if (3'(i) < rx_pop_n && lane >= 0)
                bus_rdata[8*lane +: 8] = rx_peek[8*i +: 8];
        end
    end

    hbuf_ring #(.DEPTH(DEPTH), .PUSH_W(BUS_LANES), .POP_W(1)) u_tx_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_n   (tx_push_n),
        .push_vec (tx_push_vec),
        .pop_n    (tx_pop),
        .level    (tx_level),
        .peek_vec (card_tx_data)
    );

    hbuf_ring #(.DEPTH(DEPTH), .PUSH_W(1), .POP_W(BUS_LANES)) u_rx_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_n   (rx_push),
        .push_vec (card_rx_data),
        .pop_n    (rx_pop_n),
        .level    (rx_level),
        .peek_vec (rx_peek)
    );

    hbuf_xfer #(.CNT_W(CNT_W)) u_xfer (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_load     (xfer_load),
        .xfer_dir      (xfer_dir),
        .xfer_bytes    (xfer_bytes),
        .tx_flush      (tx_flush),
        .tx_empty      (tx_level == '0),
        .tx_full       (tx_level == LVL_W'(DEPTH)),
        .tx_last       ((tx_level == LVL_W'(1)) && (tx_push_n == '0)),
        .rx_full       (rx_level == LVL_W'(DEPTH)),
        .card_tx_ready (card_tx_ready),
        .card_rx_valid (card_rx_valid),
        .card_tx_valid (card_tx_valid),
        .card_rx_ready (card_rx_ready),
        .tx_pop        (tx_pop),
        .rx_push       (rx_push),
        .ev_tx_start   (ev_tx_start),
        .ev_tx_drained (ev_tx_drained),
        .ev_last       (ev_last),
        .data_done     (data_done),
        .prog_done     (prog_done)
    );

    assign rx_fill_evt = rx_push &&
        ((rx_level + LVL_W'(1) - LVL_W'(rx_pop_n)) == LVL_W'(DEPTH));

    // Service requests: set has priority over the bus-side clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_req <= 1'b0;
            tx_req <= 1'b0;
        end else begin
            if (rx_fill_evt || (rx_push && ev_last)) rx_req <= 1'b1;
            else if (bus_rd)                         rx_req <= 1'b0;
            if (ev_tx_start || ev_tx_drained)        tx_req <= 1'b1;
            else if (bus_wr)                         tx_req <= 1'b0;
        end
    end
endmodule

// File: rtl/hbuf_checker.sv
module hbuf_checker #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic             card_tx_valid,
    input logic             card_rx_ready,
    input logic             bus_rd,
    input logic [31:0]      bus_rdata,
    input logic             rx_req,
    input logic             data_done,
    input logic             prog_done
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

    assert_no_send_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_valid |-> (tx_level != '0));

    assert_no_fill_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (rx_level < LVL_W'(DEPTH)));

    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && rx_level == '0) |-> (bus_rdata == 32'h0));

    assert_rxreq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !card_rx_ready) |=> !rx_req);

    assert_prog_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |-> data_done);
endmodule

bind hbuf_top hbuf_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_level      (tx_level),
    .rx_level      (rx_level),
    .card_tx_valid (card_tx_valid),
    .card_rx_ready (card_rx_ready),
    .bus_rd        (bus_rd),
    .bus_rdata     (bus_rdata),
    .rx_req        (rx_req),
    .data_done     (data_done),
    .prog_done     (prog_done)
);

// File: tb/sim_hbuf_top.sv
module sim_hbuf_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]       bus_size = 2'd0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic             tx_flush = 1'b0;
    logic             xfer_load = 1'b0, xfer_dir = 1'b0;
    logic [CNT_W-1:0] xfer_bytes = '0;
    logic             card_tx_valid, card_tx_ready = 1'b1;
    logic [7:0]       card_tx_data;
    logic             card_rx_valid = 1'b0, card_rx_ready;
    logic [7:0]       card_rx_data = 8'h40;
    logic             rx_req, tx_req, data_done, prog_done;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    hbuf_top #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    // Monitor: every byte handed to the card must match the scoreboard (R3, R7).
    always @(negedge clk) begin
        if (rst_n && card_tx_valid && card_tx_ready) begin
            if (txq.size() == 0) begin
                n_checks++;
                n_bad++;
                $display("FAIL R7 extra byte actual=%h expected=none", card_tx_data);
            end else begin
                check("R7 card byte order", {24'h0, card_tx_data}, {24'h0, txq.pop_front()});
            end
        end
    end

    // Card source: accepted bytes enter the receive scoreboard after the edge.
    initial begin
        logic fire;
        forever begin
            @(negedge clk);
            fire = card_rx_valid && card_rx_ready;
            @(posedge clk);
            #1;
            if (fire) begin
                rxq.push_back(card_rx_data);
                card_rx_data = card_rx_data + 8'd1;
            end
        end
    end

    function automatic int width_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    // Driver: push the bytes the write should be accepted into the scoreboard.
    task automatic bus_write(input logic [1:0] sz, input logic [31:0] d);
        int w, room;
        w = width_of(sz);
        @(posedge clk); #1;
        room = DEPTH - txq.size();
        for (int i = 0; i < w && i < room; i++)
            txq.push_back(d[8*(w-1-i) +: 8]);
        bus_wr = 1'b1; bus_size = sz; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sz, input string req);
        int w;
        logic [31:0] exp;
        w = width_of(sz);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_size = sz;
        @(negedge clk);
        exp = '0;
        for (int i = 0; i < w; i++)
            if (rxq.size() > 0) exp[8*(w-1-i) +: 8] = rxq.pop_front();
        check(req, bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic load(input logic dir, input int n);
        @(posedge clk); #1;
        xfer_load = 1'b1; xfer_dir = dir; xfer_bytes = CNT_W'(n);
        @(posedge clk); #1;
        xfer_load = 1'b0;
    endtask

    task automatic flush();
        @(posedge clk); #1;
        tx_flush = 1'b1;
        @(posedge clk); #1;
        tx_flush = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset tx_req", {31'h0, tx_req}, 32'h0);
        check("R6 reset rx_req", {31'h0, rx_req}, 32'h0);
        check("R10 reset done", {30'h0, data_done, prog_done}, 32'h0);
        check("R7 reset no offer", {31'h0, card_tx_valid}, 32'h0);
        check("R5 reset no accept", {31'h0, card_rx_ready}, 32'h0);

        // Card write of 40 bytes: one full burst, then two flushed bursts.
        load(1'b1, 40);
        @(negedge clk);
        check("R8 tx_req on load", {31'h0, tx_req}, 32'h1);
        for (int i = 0; i < 7; i++)
            bus_write(2'd2, 32'h10203040 + 32'h01010101 * i);
        @(negedge clk);
        check("R8 tx_req cleared by write", {31'h0, tx_req}, 32'h0);
        check("R7 hold until full", {31'h0, card_tx_valid}, 32'h0);
        bus_write(2'd2, 32'h90A0B0C0);
        wait_cycles(40);
        check("R7 full burst sent", 32'(txq.size()), 32'h0);
        check("R8 tx_req after burst", {31'h0, tx_req}, 32'h1);
        check("R10 not done mid transfer", {31'h0, data_done}, 32'h0);
        bus_write(2'd2, 32'hA1B2C3D4);
        wait_cycles(3);
        check("R9 partial held before flush", {31'h0, card_tx_valid}, 32'h0);
        flush();
        wait_cycles(10);
        check("R9 flushed bytes sent", 32'(txq.size()), 32'h0);
        check("R8 tx_req after flushed burst", {31'h0, tx_req}, 32'h1);
        bus_write(2'd1, 32'h5555E5F6);
        bus_write(2'd1, 32'h77771234);
        flush();
        wait_cycles(10);
        check("R10 write done flags", {30'h0, data_done, prog_done}, 32'h3);
        check("R10 idle after last", {31'h0, card_tx_valid}, 32'h0);

        // Overfilled write: only the top lane of the last word fits.
        card_tx_ready = 1'b0;
        load(1'b1, 32);
        @(negedge clk);
        check("R10 load clears done", {30'h0, data_done, prog_done}, 32'h0);
        for (int i = 0; i < 7; i++)
            bus_write(2'd2, 32'h01020304 + 32'h04040404 * i);
        bus_write(2'd1, 32'hFFFF9A9B);
        bus_write(2'd0, 32'hFFFFFFC7);
        bus_write(2'd2, 32'hDDEEFF11);
        @(negedge clk);
        check("R3 queue holds full depth", 32'(txq.size()), 32'd32);
        card_tx_ready = 1'b1;
        wait_cycles(40);
        check("R3 overflow bytes dropped", 32'(txq.size()), 32'h0);
        check("R10 second write done", {30'h0, data_done, prog_done}, 32'h3);
        check("R1 nothing left to offer", {31'h0, card_tx_valid}, 32'h0);

        // Card read of 35 bytes through a 32-byte queue.
        load(1'b0, 35);
        card_rx_valid = 1'b1;
        @(negedge clk);
        check("R10 read load clears done", {30'h0, data_done, prog_done}, 32'h0);
        wait_cycles(40);
        check("R1 receive queue stops at depth", 32'(rxq.size()), 32'd32);
        check("R5 no accept when full", {31'h0, card_rx_ready}, 32'h0);
        check("R6 rx_req on full", {31'h0, rx_req}, 32'h1);
        check("R10 read not done yet", {31'h0, data_done}, 32'h0);
        bus_read(2'd2, "R4 word read");
        @(negedge clk);
        check("R6 rx_req cleared by read", {31'h0, rx_req}, 32'h0);
        wait_cycles(10);
        check("R10 read done, no program", {30'h0, data_done, prog_done}, 32'h2);
        check("R6 rx_req on last byte", {31'h0, rx_req}, 32'h1);
        check("R5 stop at zero count", {31'h0, card_rx_ready}, 32'h0);
        check("R1 wrapped contents", 32'(rxq.size()), 32'd31);
        bus_read(2'd0, "R2 byte read");
        bus_read(2'd1, "R2 halfword read");
        for (int i = 0; i < 5; i++)
            bus_read(2'd2, "R4 word read");
        bus_read(2'd3, "R2 code 3 reads a word");
        bus_read(2'd0, "R2 byte read");
        bus_read(2'd2, "R4 short read zero fill");
        bus_read(2'd2, "R4 empty read");
        check("R1 receive queue drained", 32'(rxq.size()), 32'h0);
        card_rx_valid = 1'b0;

        finish_run();
    end
endmodule